// File: doc/BRIEF.md
# Frame-Aligned Serial ADC Deserializer

This block turns the one-wire-per-channel serial output of a multichannel ADC back into parallel 12-bit samples. It runs entirely in the bit-clock domain. Every cycle it receives two bits for each data lane and two bits for the frame lane, already split by an upstream double-data-rate input register into the bit caught on the rising edge and the bit caught on the falling edge. Delay tuning, clock buffering and pin placement happen upstream and are not part of this block.

The frame lane is not used as a clock. It goes through the same two-bit capture path as the data and is then read as a data pattern: six bit periods high, six low. A low bit followed by a high bit marks the first bit of a new sample. That transition can fall inside one bit-clock cycle or across two cycles, so the block records which of the two alignments it found. On each such boundary every lane copies its last twelve shifted bits into a holding register at the same instant, and a one-cycle valid strobe is raised. A lock flag reports whether the frame pattern has kept a steady period. The captured frame level is also presented as the sample-rate clock, as a registered level in the bit-clock domain.

Top module: `serial_adc_deser`

## Requirements
- R1: Within one cycle the rising-edge bit is the older of the two bits. Samples are sent most-significant bit first, so bit 11 of a loaded word is the first of its twelve bits on the wire.
- R2: When the previous cycle's falling-edge frame bit is 0 and the current rising-edge frame bit is 1, the sample that ended on the previous falling edge is loaded, and `sample_phase` reads 0.
- R3: When the current rising-edge frame bit is 0 and the current falling-edge frame bit is 1, the sample ending on the current rising edge is loaded, and `sample_phase` reads 1.
- R4: All lanes load on the same frame event, covered by a single `sample_valid`. Lane k occupies `sample_data[12k+11:12k]`.
- R5: `sample_valid` is high for exactly one cycle per loaded sample, in the cycle after the boundary bits are presented. The first boundary after reset or after a timeout only arms the block and produces no strobe.
- R6: Between strobes `sample_data` holds its last loaded value, whatever arrives on the data lanes.
- R7: `frame_locked` goes high together with the strobe of the third consecutive boundary that is exactly 6 cycles after the previous one and has the same phase.
- R8: A boundary that comes at any spacing other than 6 cycles, or with a changed phase, clears `frame_locked` and restarts the match count. That sample is still loaded.
- R9: If 6 cycles pass after a boundary without a new one, `frame_locked` clears and the block disarms.
- R10: `sample_clk` equals the rising-edge frame bit presented in the previous cycle.
- R11: A low `rst_n` at a clock edge clears the shift registers, `sample_data`, `sample_valid`, `sample_phase`, `frame_locked` and `sample_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one cycle per two serial bits) |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_rise | input | 8 | Rising-edge bit of each data lane |
| lane_fall | input | 8 | Falling-edge bit of each data lane |
| frame_rise | input | 1 | Rising-edge bit of the frame lane |
| frame_fall | input | 1 | Falling-edge bit of the frame lane |
| sample_data | output | 96 | Held parallel samples, 12 bits per lane |
| sample_valid | output | 1 | One-cycle strobe per loaded sample |
| sample_phase | output | 1 | Alignment of the last boundary (0 across cycles, 1 within a cycle) |
| frame_locked | output | 1 | Frame period has been steady for three samples |
| sample_clk | output | 1 | Registered frame level used as the sample-rate clock |

## Verification
If the boundary phase or the shift window is wrong, the loaded words come out rotated by one bit. Every lane shows this on the first strobe after the boundary, because each sample has its own distinct bit pattern. A miscounted period register shows up in `frame_locked`. The flag rises one strobe early or late, stays high through a shortened frame, or stays high after the frame goes idle, and each of these is visible within one sample period. A faulty arm or timeout path shows up as an extra strobe that the scoreboard has no entry for, or as a missing strobe that leaves entries in the queue.

// File: rtl/adc_deser_pkg.sv
// Package: shared types for the serial ADC deserializer.
// Assumes: each sample has an even number of bits, two bits arrive per cycle.
package adc_deser_pkg;

    // Where the frame low-to-high edge fell relative to the bit-clock cycle
    typedef enum logic {
        PH_ACROSS = 1'b0,   // previous falling bit low, current rising bit high
        PH_WITHIN = 1'b1    // current rising bit low, current falling bit high
    } frame_phase_e;

    // Returns the number of bit-clock cycles needed for one sample
    function automatic int cycles_per_sample(input int sample_bits);
        return sample_bits / 2;
    endfunction

endpackage

// File: rtl/sad_lane_shifter.sv
// Module: one lane's shift chain and parallel holding register.
// Shifts two bits in per cycle (rising bit first, older) and, on load, copies
// the twelve-bit window that the boundary phase selects.
// Assumes: SAMPLE_BITS is even and at least 4.
module sad_lane_shifter
    import adc_deser_pkg::*;
#(
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_rise,
    input  logic                   bit_fall,
    input  logic                   load,
    input  frame_phase_e           phase,
    output logic [SAMPLE_BITS-1:0] word_o
);

    logic [SAMPLE_BITS-1:0] shreg;
    logic [SAMPLE_BITS-1:0] window;

    // Choose the twelve most recent bits that end just before the sample start
    always_comb begin
        if (phase == PH_WITHIN) begin
            window = {shreg[SAMPLE_BITS-2:0], bit_rise};
        end else begin
            window = shreg;
        end
    end

    // Shift chain: the older rising bit lands above the newer falling bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SAMPLE_BITS-3:0], bit_rise, bit_fall};
        end
    end

    // Holding register: takes a new word only on a boundary load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (load) begin
            word_o <= window;
        end
    end

endmodule

// File: rtl/sad_frame_detect.sv
// Module: reads the captured frame lane as data and finds sample starts.
// Flags a boundary where a low frame bit is followed by a high one, and gives
// the phase of that edge. Also registers the frame level as the sample clock.
// Assumes: the frame lane passed through the same capture path as the data.
module sad_frame_detect
    import adc_deser_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_rise,
    input  logic         frame_fall,
    output logic         boundary,
    output frame_phase_e boundary_phase,
    output logic         sample_clk
);

    logic prev_fall;
    logic edge_across;
    logic edge_within;

    // Compare both possible positions of the low-to-high frame edge
    always_comb begin
        edge_across    = !prev_fall && frame_rise;
        edge_within    = !frame_rise && frame_fall;
        boundary       = edge_across || edge_within;
        boundary_phase = edge_within ? PH_WITHIN : PH_ACROSS;
    end

    // Keep the last frame bit of the cycle; reset high so no false edge at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fall <= 1'b1;
        end else begin
            prev_fall <= frame_fall;
        end
    end

    // Captured frame level serves as the sample-rate clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_clk <= 1'b0;
        end else begin
            sample_clk <= frame_rise;
        end
    end

endmodule

// File: rtl/sad_lock_track.sv
// Module: arms on the first frame boundary, issues loads on later ones, and
// tracks whether the boundary spacing and phase stay steady.
// Assumes: a correct frame repeats every CYC_PER_SAMPLE cycles.
module sad_lock_track
    import adc_deser_pkg::*;
#(
    parameter int CYC_PER_SAMPLE = 6,
    parameter int LOCK_MATCHES   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         boundary,
    input  frame_phase_e boundary_phase,
    output logic         load,
    output frame_phase_e phase_q,
    output logic         locked
);

    localparam int GAP_W   = $clog2(CYC_PER_SAMPLE + 2);
    localparam int MATCH_W = $clog2(LOCK_MATCHES + 1);
    localparam logic [GAP_W-1:0]   GAP_PERIOD = GAP_W'(CYC_PER_SAMPLE);
    localparam logic [GAP_W-1:0]   GAP_SAT    = GAP_W'(CYC_PER_SAMPLE + 1);
    localparam logic [MATCH_W-1:0] MATCH_LAST = MATCH_W'(LOCK_MATCHES - 1);
    localparam logic [MATCH_W-1:0] MATCH_MAX  = MATCH_W'(LOCK_MATCHES);

    logic               armed;
    logic [GAP_W-1:0]   gap;
    logic [MATCH_W-1:0] match_cnt;
    logic               spacing_ok;
    logic               timed_out;

    // Decide whether this boundary continues the steady pattern
    always_comb begin
        spacing_ok = (gap == GAP_PERIOD) && (boundary_phase == phase_q);
        timed_out  = !boundary && armed && (gap >= GAP_PERIOD);
        load       = boundary && armed;
    end

    // Cycles since the last boundary, saturating past one period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (boundary) begin
            gap <= GAP_W'(1);
        end else if (gap < GAP_SAT) begin
            gap <= gap + 1'b1;
        end
    end

    // Arm on any boundary, disarm when the frame stops arriving
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (boundary) begin
            armed <= 1'b1;
        end else if (timed_out) begin
            armed <= 1'b0;
        end
    end

    // Phase of the most recent boundary selects the load window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACROSS;
        end else if (boundary) begin
            phase_q <= boundary_phase;
        end
    end

    // Count consecutive good spacings and raise lock after enough of them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_cnt <= '0;
            locked    <= 1'b0;
        end else if (boundary) begin
            if (!armed) begin
                match_cnt <= '0;
                locked    <= 1'b0;
            end else if (spacing_ok) begin
                if (match_cnt < MATCH_MAX) begin
                    match_cnt <= match_cnt + 1'b1;
                end
                if (match_cnt >= MATCH_LAST) begin
                    locked <= 1'b1;
                end
            end else begin
                match_cnt <= '0;
                locked    <= 1'b0;
            end
        end else if (timed_out) begin
            match_cnt <= '0;
            locked    <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_adc_deser.sv
// Module: top of the frame-aligned serial ADC deserializer.
// Takes pre-split rising/falling bits of every lane and of the frame lane,
// finds sample starts in the frame pattern, and loads all lanes together.
// Assumes: upstream input registers already meet timing on both clock edges.
module serial_adc_deser
    import adc_deser_pkg::*;
#(
    parameter int NUM_LANES    = 8,
    parameter int SAMPLE_BITS  = 12,
    parameter int LOCK_MATCHES = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_LANES-1:0]             lane_rise,
    input  logic [NUM_LANES-1:0]             lane_fall,
    input  logic                             frame_rise,
    input  logic                             frame_fall,
    output logic [NUM_LANES*SAMPLE_BITS-1:0] sample_data,
    output logic                             sample_valid,
    output logic                             sample_phase,
    output logic                             frame_locked,
    output logic                             sample_clk
);

    localparam int CYC_PER_SAMPLE = cycles_per_sample(SAMPLE_BITS);

    logic         boundary;
    frame_phase_e boundary_phase;
    logic         load;
    frame_phase_e phase_q;

    sad_frame_detect u_detect (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_rise     (frame_rise),
        .frame_fall     (frame_fall),
        .boundary       (boundary),
        .boundary_phase (boundary_phase),
        .sample_clk     (sample_clk)
    );

    sad_lock_track #(
        .CYC_PER_SAMPLE (CYC_PER_SAMPLE),
        .LOCK_MATCHES   (LOCK_MATCHES)
    ) u_lock (
        .clk            (clk),
        .rst_n          (rst_n),
        .boundary       (boundary),
        .boundary_phase (boundary_phase),
        .load           (load),
        .phase_q        (phase_q),
        .locked         (frame_locked)
    );

    // One shifter per lane, all sharing the same load and phase
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sad_lane_shifter #(
            .SAMPLE_BITS (SAMPLE_BITS)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_rise (lane_rise[g]),
            .bit_fall (lane_fall[g]),
            .load     (load),
            .phase    (boundary_phase),
            .word_o   (sample_data[g*SAMPLE_BITS +: SAMPLE_BITS])
        );
    end

    // Strobe aligned with the holding registers taking their new value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= load;
        end
    end

    // Expose the phase of the latest boundary
    always_comb begin
        sample_phase = (phase_q == PH_WITHIN);
    end

endmodule

// File: rtl/serial_adc_deser_chk.sv
// Module: assertion checker for the deserializer, bound to the top module.
module serial_adc_deser_chk #(
    parameter int DATA_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_rise,
    input logic [DATA_W-1:0] sample_data,
    input logic              sample_valid,
    input logic              sample_phase,
    input logic              frame_locked,
    input logic              sample_clk
);

    logic seen_edge;

    // Marks that at least one clock edge has passed, so $past is meaningful
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    // R6
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n) && !sample_valid) |-> $stable(sample_data));

    // R7
    lock_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n) && $rose(frame_locked)) |-> sample_valid);

    // R10
    sample_clk_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n)) |-> (sample_clk == $past(frame_rise)));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        (seen_edge && !$past(rst_n)) |->
        (sample_data == '0 && !sample_valid && !sample_phase && !frame_locked && !sample_clk));

endmodule

bind serial_adc_deser serial_adc_deser_chk #(
    .DATA_W (NUM_LANES*SAMPLE_BITS)
) u_deser_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_rise   (frame_rise),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .sample_phase (sample_phase),
    .frame_locked (frame_locked),
    .sample_clk   (sample_clk)
);

// File: tb/serial_adc_deser_bench.sv
`timescale 1ns/1ps
module serial_adc_deser_bench;

    localparam int NL = 8;
    localparam int SB = 12;
    localparam int DW = NL*SB;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          phase;
        logic          lock;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lane_rise = '0;
    logic [NL-1:0] lane_fall = '0;
    logic          frame_rise = 1'b0;
    logic          frame_fall = 1'b0;
    logic [DW-1:0] sample_data;
    logic          sample_valid;
    logic          sample_phase;
    logic          frame_locked;
    logic          sample_clk;

    int checks = 0;
    int errors = 0;
    logic [NL:0]   stream_q[$];
    exp_t          exp_q[$];
    logic [DW-1:0] last_data = '0;

    always #2 clk = ~clk;

    serial_adc_deser u_serial_adc_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_rise    (lane_rise),
        .lane_fall    (lane_fall),
        .frame_rise   (frame_rise),
        .frame_fall   (frame_fall),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .sample_phase (sample_phase),
        .frame_locked (frame_locked),
        .sample_clk   (sample_clk)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [SB-1:0] word_of(input int burst, input int s, input int l);
        return SB'(12'h5A3 + s*12'h2C9 + l*12'h137 + burst*12'h611);
    endfunction

    function automatic logic [DW-1:0] pack(input int burst, input int s);
        logic [DW-1:0] v;
        for (int l = 0; l < NL; l++) v[l*SB +: SB] = word_of(burst, s, l);
        return v;
    endfunction

    task automatic add_idle(input int n);
        repeat (n) stream_q.push_back('0);
    endtask

    // Frame high for the first half of len bits; data MSB first (R1)
    task automatic add_frame(input int len, input logic [DW-1:0] w);
        for (int b = 0; b < len; b++) begin
            logic [NL:0] e;
            e[NL] = (b < len/2);
            for (int l = 0; l < NL; l++) e[l] = w[l*SB + (len-1-b)];
            stream_q.push_back(e);
        end
    endtask

    // Two stream bits per cycle: the first popped is the rising-edge bit
    task automatic drive_stream();
        while (stream_q.size() > 0) begin
            logic [NL:0] a;
            logic [NL:0] b;
            a = stream_q.pop_front();
            b = (stream_q.size() > 0) ? stream_q.pop_front() : '0;
            @(negedge clk);
            lane_rise  = a[NL-1:0];
            frame_rise = a[NL];
            lane_fall  = b[NL-1:0];
            frame_fall = b[NL];
        end
        @(negedge clk);
        lane_rise = '0; lane_fall = '0; frame_rise = 1'b0; frame_fall = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: queues a steady burst and the scoreboard items it must produce
    task automatic run_burst(input int burst, input int lead, input int nsamp, input int trail);
        logic ph;
        ph = 1'(lead % 2);
        add_idle(lead);
        for (int s = 0; s < nsamp; s++) begin
            exp_t e;
            add_frame(SB, pack(burst, s));
            e.data = pack(burst, s);
            e.phase = ph;
            e.lock = (s >= 2);
            exp_q.push_back(e);
        end
        add_frame(SB, pack(burst, 99));
        add_idle(trail);
        drive_stream();
    endtask

    // Monitor: pops the scoreboard on each strobe and checks holding between strobes
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            last_data = '0;
        end else begin
            check(sample_clk == frame_rise, "R10 sample_clk", DW'(sample_clk), DW'(frame_rise));
            if (sample_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected sample_valid", DW'(1), DW'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sample_data == e.data, "R1 R4 sample_data", sample_data, e.data);
                    check(sample_phase == e.phase, e.phase ? "R3 phase" : "R2 phase",
                          DW'(sample_phase), DW'(e.phase));
                    check(frame_locked == e.lock, e.lock ? "R7 lock" : "R8 lock",
                          DW'(frame_locked), DW'(e.lock));
                end
                last_data = sample_data;
            end else begin
                check(sample_data == last_data, "R6 hold", sample_data, last_data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        exp_t e;
        logic [DW-1:0] sh;
        logic [DW-1:0] prev;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sample_data == '0 && !sample_valid && !frame_locked && !sample_phase && !sample_clk,
              "R11 reset state", sample_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 boundary across cycles, R7 lock from third strobe
        run_burst(0, 4, 5, 20);
        check(exp_q.size() == 0, "R5 burst0 strobes", DW'(exp_q.size()), '0);
        check(!frame_locked, "R9 timeout clears lock", DW'(frame_locked), '0);

        // R3 boundary within a cycle
        run_burst(1, 3, 5, 21);
        check(exp_q.size() == 0, "R5 burst1 strobes", DW'(exp_q.size()), '0);
        check(!frame_locked, "R9 timeout clears lock", DW'(frame_locked), '0);

        // R7 two samples do not reach lock
        run_burst(2, 6, 2, 20);
        check(exp_q.size() == 0, "R5 burst2 strobes", DW'(exp_q.size()), '0);

        // R8 shortened frame breaks lock, which then rebuilds
        add_idle(4);
        for (int s = 0; s < 4; s++) begin
            add_frame(SB, pack(3, s));
            e.data = pack(3, s); e.phase = 1'b0; e.lock = (s >= 2);
            exp_q.push_back(e);
        end
        sh = pack(3, 50);
        add_frame(10, sh);
        prev = pack(3, 3);
        for (int l = 0; l < NL; l++) e.data[l*SB +: SB] = {prev[l*SB +: 2], sh[l*SB +: 10]};
        e.phase = 1'b0; e.lock = 1'b0;
        exp_q.push_back(e);
        for (int s = 4; s < 8; s++) begin
            add_frame(SB, pack(3, s));
            e.data = pack(3, s); e.phase = 1'b0; e.lock = (s >= 6);
            exp_q.push_back(e);
        end
        add_frame(SB, pack(3, 99));
        add_idle(20);
        drive_stream();
        check(exp_q.size() == 0, "R8 burst3 strobes", DW'(exp_q.size()), '0);
        check(!frame_locked, "R9 timeout clears lock", DW'(frame_locked), '0);

        // R11 reset clears held data after activity
        check(sample_data != '0, "R11 data held before reset", sample_data, pack(3, 7));
        rst_n = 1'b0;
        @(negedge clk);
        check(sample_data == '0 && !sample_valid && !frame_locked && !sample_phase,
              "R11 reset clears", sample_data, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule